// File: doc/BRIEF.md
# Dual Latched Interval Timer Pair

This block holds two 16-bit down-counters behind an 8-bit register bus of a general-purpose interface peripheral. The host selects a register with the low nibble of the bus address. It writes reload values in bytes and reads the live counts back.

The first timer keeps a 16-bit reload latch that is separate from its counter. The host can read either one, low and high byte apart. Writing the high byte at one offset only stores it. Writing it at the other offset also copies the whole latch into the counter and arms the timer. An input selects one-shot or free-running behaviour. In free-running mode the counter reloads from the latch each time it underflows.

The second timer has only an 8-bit low latch. Writing its high byte loads the counter and arms it. It always behaves as a one-shot. Each timer sends a one-cycle flag-set pulse to the interrupt logic when an armed count wraps from 0x0000 to 0xFFFF. It also sends a one-cycle clear request when the host accesses a register that acknowledges that timer.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both counters, the two timer-1 latch bytes and the timer-2 low latch read 0x00. All four pulse outputs are low, and neither timer is armed.
- R2: Only busAddr[3:0] selects a register. Higher address bits are ignored for both reads and writes.
- R3: A write to offset 0x4 or 0x6 replaces the timer-1 latch low byte and leaves the latch high byte unchanged. Offset 0x6 reads the latch low byte and offset 0x7 reads the latch high byte.
- R4: A write to offset 0x7 replaces the timer-1 latch high byte and leaves the timer-1 counter unchanged. t1ClrReq is high for the one cycle after that write edge.
- R5: A write to offset 0x5 stores the latch high byte and loads the counter with {written byte, latch low byte}. It arms timer 1, and t1ClrReq is high for the one following cycle.
- R6: Offset 0x4 reads the timer-1 counter low byte, and a strobed read there raises t1ClrReq for one cycle. Offset 0x5 reads the counter high byte. Strobed reads of 0x5, 0x6 and 0x7 raise no clear request.
- R7: With tickEn high, each clock edge decrements each counter by one. With tickEn low and no load, both counters hold their values.
- R8: With freeRun low, an armed timer 1 whose counter moves from 0x0000 to 0xFFFF gives one t1SetPulse in the cycle after that edge. It then disarms and keeps counting down with no further pulses.
- R9: With freeRun high, an armed timer 1 reloads its counter from the latch on underflow instead of wrapping. It pulses t1SetPulse once per period of latch+1 enabled cycles.
- R10: A write to offset 0x8 stores the timer-2 low latch. A write to offset 0x9 loads the timer-2 counter with {written byte, low latch}, arms timer 2 and raises t2ClrReq for one cycle.
- R11: Offset 0x8 reads the timer-2 counter low byte, and a strobed read there raises t2ClrReq for one cycle. Offset 0x9 reads the counter high byte and has no side effect.
- R12: An armed timer 2 gives one t2SetPulse in the cycle after its counter wraps from 0x0000 to 0xFFFF. It then keeps decrementing with no further pulses until it is loaded again.
- R13: Offsets other than 0x4 to 0x9 read 0x00, and a write to them changes no timer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count enable for both counters |
| freeRun | input | 1 | Timer-1 mode: 1 = reload on underflow, 0 = one-shot |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (side effects only) |
| busAddr | input | ADDR_W | Register address, low nibble decoded |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from busAddr |
| t1SetPulse | output | 1 | Timer-1 flag-set pulse |
| t1ClrReq | output | 1 | Timer-1 flag-clear request |
| t2SetPulse | output | 1 | Timer-2 flag-set pulse |
| t2ClrReq | output | 1 | Timer-2 flag-clear request |

## Verification
Read data is combinational, so the bench samples rdData in the same cycle it sets busAddr, before any side effect. Clear requests and loaded counts take effect on the edge of the access and are checked at the falling edge after it. A set pulse appears in the cycle after the edge on which the count wraps. The bench therefore counts enabled edges from the load: with a loaded value N, the pulse is checked after edge N+1 and its absence on the edges around it. In free-running mode the pulse repeats every N+1 edges.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;
  localparam int SEL_W = 4;

  localparam logic [SEL_W-1:0] OFS_T1_CNT_LO = 4'h4;
  localparam logic [SEL_W-1:0] OFS_T1_CNT_HI = 4'h5;
  localparam logic [SEL_W-1:0] OFS_T1_LAT_LO = 4'h6;
  localparam logic [SEL_W-1:0] OFS_T1_LAT_HI = 4'h7;
  localparam logic [SEL_W-1:0] OFS_T2_CNT_LO = 4'h8;
  localparam logic [SEL_W-1:0] OFS_T2_CNT_HI = 4'h9;

  typedef struct packed {
    logic t1LatLoWr;
    logic t1LatHiWr;
    logic t1Start;
    logic t1ClrHit;
    logic t2LatWr;
    logic t2Start;
    logic t2ClrHit;
  } strobe_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import dual_timer_pkg::*;
(
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [SEL_W-1:0] regSel,
  output strobe_t          strb
);
  always_comb begin
    strb = '0;
    strb.t1LatLoWr = wrEn && (regSel == OFS_T1_CNT_LO || regSel == OFS_T1_LAT_LO);
    strb.t1LatHiWr = wrEn && (regSel == OFS_T1_CNT_HI || regSel == OFS_T1_LAT_HI);
    strb.t1Start   = wrEn && (regSel == OFS_T1_CNT_HI);
    strb.t1ClrHit  = strb.t1LatHiWr || (rdEn && regSel == OFS_T1_CNT_LO);
    strb.t2LatWr   = wrEn && (regSel == OFS_T2_CNT_LO);
    strb.t2Start   = wrEn && (regSel == OFS_T2_CNT_HI);
    strb.t2ClrHit  = strb.t2Start || (rdEn && regSel == OFS_T2_CNT_LO);
  end
endmodule

// File: rtl/timer_channel.sv
module timer_channel #(
  parameter int CNT_W      = 16,
  parameter bit HAS_RELOAD = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             freeRun,
  input  logic             load,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] cnt,
  output logic             setPulse
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      armed    <= 1'b0;
      setPulse <= 1'b0;
    end else begin
      setPulse <= 1'b0;
      if (load) begin
        cnt   <= loadVal;
        armed <= 1'b1;
      end else if (tick) begin
        if (cnt == '0 && armed) begin
          setPulse <= 1'b1;
          if (HAS_RELOAD && freeRun) begin
            cnt <= reloadVal;
          end else begin
            cnt   <= cnt - 1'b1;
            armed <= 1'b0;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import dual_timer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              freeRun,
  input  strobe_t           strb,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              t1SetPulse,
  output logic              t1ClrReq,
  output logic              t2SetPulse,
  output logic              t2ClrReq
);
  localparam int CNT_W = 2 * DATA_W;

  logic [DATA_W-1:0] t1LatLo, t1LatHi, t2LatLo;
  logic [CNT_W-1:0]  t1Cnt, t2Cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      t1LatLo  <= '0;
      t1LatHi  <= '0;
      t2LatLo  <= '0;
      t1ClrReq <= 1'b0;
      t2ClrReq <= 1'b0;
    end else begin
      if (strb.t1LatLoWr) t1LatLo <= wrData;
      if (strb.t1LatHiWr) t1LatHi <= wrData;
      if (strb.t2LatWr)   t2LatLo <= wrData;
      t1ClrReq <= strb.t1ClrHit;
      t2ClrReq <= strb.t2ClrHit;
    end
  end

  timer_channel #(.CNT_W(CNT_W), .HAS_RELOAD(1'b1)) u_t1 (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tickEn),
    .freeRun  (freeRun),
    .load     (strb.t1Start),
    .loadVal  ({wrData, t1LatLo}),
    .reloadVal({t1LatHi, t1LatLo}),
    .cnt      (t1Cnt),
    .setPulse (t1SetPulse)
  );

  timer_channel #(.CNT_W(CNT_W), .HAS_RELOAD(1'b0)) u_t2 (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tickEn),
    .freeRun  (1'b0),
    .load     (strb.t2Start),
    .loadVal  ({wrData, t2LatLo}),
    .reloadVal({wrData, t2LatLo}),
    .cnt      (t2Cnt),
    .setPulse (t2SetPulse)
  );

  always_comb begin
    unique case (regSel)
      OFS_T1_CNT_LO: rdData = t1Cnt[DATA_W-1:0];
      OFS_T1_CNT_HI: rdData = t1Cnt[CNT_W-1:DATA_W];
      OFS_T1_LAT_LO: rdData = t1LatLo;
      OFS_T1_LAT_HI: rdData = t1LatHi;
      OFS_T2_CNT_LO: rdData = t2Cnt[DATA_W-1:0];
      OFS_T2_CNT_HI: rdData = t2Cnt[CNT_W-1:DATA_W];
      default:       rdData = '0;
    endcase
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dual_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              freeRun,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              t1SetPulse,
  output logic              t1ClrReq,
  output logic              t2SetPulse,
  output logic              t2ClrReq
);
  logic [SEL_W-1:0] regSel;
  logic             unusedHighAddr;
  strobe_t          strb;

  assign regSel         = busAddr[SEL_W-1:0];
  assign unusedHighAddr = ^busAddr[ADDR_W-1:SEL_W];

  timer_ctrl u_ctrl (
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .regSel(regSel),
    .strb  (strb)
  );

  timer_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .freeRun   (freeRun),
    .strb      (strb),
    .regSel    (regSel),
    .wrData    (wrData),
    .rdData    (rdData),
    .t1SetPulse(t1SetPulse),
    .t1ClrReq  (t1ClrReq),
    .t2SetPulse(t2SetPulse),
    .t2ClrReq  (t2ClrReq)
  );
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              freeRun,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              t1SetPulse,
  input logic              t1ClrReq,
  input logic              t2SetPulse,
  input logic              t2ClrReq
);
  // R8
  t1_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (t1SetPulse && $past(!freeRun)) |=> !t1SetPulse);

  // R12
  t2_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    t2SetPulse |=> !t2SetPulse);

  // R6
  t1_read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && busAddr[3:0] == 4'h4) |=> t1ClrReq);

  // R10
  t2_write_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busAddr[3:0] == 4'h9) |=> t2ClrReq);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!tickEn && !wrEn) && $stable(busAddr)) |-> $stable(rdData));

  // R7
  no_tick_no_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!tickEn) |-> !(t1SetPulse || t2SetPulse));
endmodule

bind dual_interval_timer dual_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tickEn    (tickEn),
  .freeRun   (freeRun),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .busAddr   (busAddr),
  .rdData    (rdData),
  .t1SetPulse(t1SetPulse),
  .t1ClrReq  (t1ClrReq),
  .t2SetPulse(t2SetPulse),
  .t2ClrReq  (t2ClrReq)
);

// File: tb/tb_dual_interval_timer.sv
module tb_dual_interval_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       freeRun = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] busAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       t1SetPulse, t1ClrReq, t2SetPulse, t2ClrReq;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  dual_interval_timer dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .freeRun(freeRun),
    .wrEn(wrEn), .rdEn(rdEn), .busAddr(busAddr), .wrData(wrData),
    .rdData(rdData), .t1SetPulse(t1SetPulse), .t1ClrReq(t1ClrReq),
    .t2SetPulse(t2SetPulse), .t2ClrReq(t2ClrReq)
  );

  typedef struct packed {
    logic       wr;
    logic       rd;
    logic [7:0] addr;
    logic [7:0] data;
    logic [7:0] expRd;
    logic       expC1;
    logic       expC2;
    logic [7:0] req;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 8'h04, 8'h34, 8'h00, 1'b0, 1'b0, 8'd3},   // R3 latch low via 0x4
    '{1'b0, 1'b1, 8'h06, 8'h00, 8'h34, 1'b0, 1'b0, 8'd3},   // R3 read latch low
    '{1'b1, 1'b0, 8'h16, 8'h12, 8'h34, 1'b0, 1'b0, 8'd2},   // R2 0x16 acts as 0x6
    '{1'b0, 1'b1, 8'h06, 8'h00, 8'h12, 1'b0, 1'b0, 8'd3},   // R3
    '{1'b1, 1'b0, 8'h07, 8'hAB, 8'h00, 1'b1, 1'b0, 8'd4},   // R4 latch high + clear
    '{1'b0, 1'b1, 8'h05, 8'h00, 8'h00, 1'b0, 1'b0, 8'd4},   // R4 counter untouched
    '{1'b0, 1'b1, 8'h07, 8'h00, 8'hAB, 1'b0, 1'b0, 8'd3},   // R3 read latch high
    '{1'b1, 1'b0, 8'h05, 8'h56, 8'h00, 1'b1, 1'b0, 8'd5},   // R5 load + start
    '{1'b0, 1'b1, 8'h05, 8'h00, 8'h56, 1'b0, 1'b0, 8'd5},   // R5 counter high
    '{1'b0, 1'b1, 8'h04, 8'h00, 8'h12, 1'b1, 1'b0, 8'd6},   // R6 read low clears
    '{1'b0, 1'b1, 8'h07, 8'h00, 8'h56, 1'b0, 1'b0, 8'd5},   // R5 latch high updated
    '{1'b1, 1'b0, 8'h08, 8'h9A, 8'h00, 1'b0, 1'b0, 8'd10},  // R10 latch t2
    '{1'b0, 1'b1, 8'h08, 8'h00, 8'h00, 1'b0, 1'b1, 8'd11},  // R11 read clears
    '{1'b1, 1'b0, 8'h09, 8'h3C, 8'h00, 1'b0, 1'b1, 8'd10},  // R10 load t2
    '{1'b0, 1'b1, 8'h09, 8'h00, 8'h3C, 1'b0, 1'b0, 8'd11},  // R11 high no effect
    '{1'b0, 1'b1, 8'h08, 8'h00, 8'h9A, 1'b0, 1'b1, 8'd11},  // R11
    '{1'b1, 1'b0, 8'h0A, 8'hFF, 8'h00, 1'b0, 1'b0, 8'd13},  // R13 unused write
    '{1'b0, 1'b1, 8'h0A, 8'h00, 8'h00, 1'b0, 1'b0, 8'd13},  // R13 unused read
    '{1'b0, 1'b1, 8'h04, 8'h00, 8'h12, 1'b1, 1'b0, 8'd7},   // R7 held with tickEn low
    '{1'b0, 1'b1, 8'h19, 8'h00, 8'h3C, 1'b0, 1'b0, 8'd2}    // R2 0x19 acts as 0x9
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; tickEn = 1'b0; freeRun = 1'b0;
    wrEn = 1'b0; rdEn = 1'b0; busAddr = '0; wrData = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic access(input logic w, input logic r, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = w; rdEn = r; busAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  task automatic peek16(input logic [7:0] loA, output logic [15:0] v);
    busAddr = loA + 8'd1; #1;
    v[15:8] = rdData;
    busAddr = loA; #1;
    v[7:0] = rdData;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++; nChecks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] v;
    doReset();

    // R1 reset state
    for (int a = 4; a <= 9; a++) begin
      busAddr = 8'(a); #1;
      chk("R1 reset readback", {8'h0, rdData}, 16'h0);
    end
    chk("R1 pulses low", {12'h0, t1SetPulse, t1ClrReq, t2SetPulse, t2ClrReq}, 16'h0);

    // Vector table, tickEn low throughout
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      wrEn = VECS[i].wr; rdEn = VECS[i].rd;
      busAddr = VECS[i].addr; wrData = VECS[i].data;
      #1;
      chk($sformatf("R%0d rdData row %0d", VECS[i].req, i), {8'h0, rdData}, {8'h0, VECS[i].expRd});
      @(posedge clk);
      @(negedge clk);
      wrEn = 1'b0; rdEn = 1'b0;
      chk($sformatf("R%0d clr row %0d", VECS[i].req, i), {14'h0, t1ClrReq, t2ClrReq},
          {14'h0, VECS[i].expC1, VECS[i].expC2});
      chk($sformatf("R%0d no set row %0d", VECS[i].req, i), {14'h0, t1SetPulse, t2SetPulse}, 16'h0);
    end

    // R8 one-shot timer 1 with count 3, then R7 hold
    doReset();
    access(1'b1, 1'b0, 8'h04, 8'h03);
    access(1'b1, 1'b0, 8'h05, 8'h00);
    tickEn = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      @(posedge clk); @(negedge clk);
      peek16(8'h04, v);
      chk("R7 t1 count", v, 16'(3 - k));
      chk("R8 t1 one-shot pulse", {15'h0, t1SetPulse}, {15'h0, (k == 4)});
    end
    tickEn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    peek16(8'h04, v);
    chk("R7 t1 hold", v, 16'hFFFB);

    // R9 free-run timer 1 with latch 2
    doReset();
    freeRun = 1'b1;
    access(1'b1, 1'b0, 8'h06, 8'h02);
    access(1'b1, 1'b0, 8'h05, 8'h00);
    tickEn = 1'b1;
    for (int k = 1; k <= 9; k++) begin
      @(posedge clk); @(negedge clk);
      peek16(8'h04, v);
      chk("R9 t1 reload count", v, (k % 3 == 0) ? 16'd2 : 16'(2 - (k % 3)));
      chk("R9 t1 periodic pulse", {15'h0, t1SetPulse}, {15'h0, (k % 3 == 0)});
    end

    // R12 timer 2 one-shot with count 1
    doReset();
    access(1'b1, 1'b0, 8'h08, 8'h01);
    access(1'b1, 1'b0, 8'h09, 8'h00);
    tickEn = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(posedge clk); @(negedge clk);
      peek16(8'h08, v);
      chk("R12 t2 count", v, 16'(1 - k));
      chk("R12 t2 one-shot pulse", {15'h0, t2SetPulse}, {15'h0, (k == 2)});
    end

    summary();
  end
endmodule